// File: doc/BRIEF.md
# HDLC Transmit Block Buffer

This block holds outgoing frame data between a host register port and a byte-wide HDLC framer. It is a 64-byte circular store cut into fixed slots of 16 or 32 bytes, chosen by a select input. The host fills one slot at a time. A "send block" command commits the slot as part of a frame that continues. An "end frame" command commits it as the frame's final slot. A reset command flushes everything. The framer pulls bytes over a valid/ready handshake. A start marker comes with the first byte of each frame and a last marker with the final byte. A done pulse from the framer confirms that the closing flag has been sent.

Four sticky status bits report events to the host. Space ready is set whenever a slot's final byte has been taken and after a reset command. Underrun is set when the framer wants data in the middle of a frame but none is committed. Repeat request is set when a collision arrives after the frame's first slot has already been released. Overflow is set when a written byte has no room. Reading the status clears all four bits.

A collision that arrives while the first slot of the frame is still held rewinds the frame to its start. The frame is then sent again without host action. Underrun, repeat and reset all flush the store and pulse an abort request to the framer.

Top module: `hdlc_txbuf`

## Requirements
- R1: After synchronous reset all four status bits, tx_valid and tx_abort are 0.
- R2: Bytes written with wr_en are committed by cmd_xtf or cmd_xme. A byte written in the same cycle as the command is included. Committed bytes are offered in write order. tx_sof is high with the first byte offered while no frame is in progress.
- R3: A write is dropped and st_ovf is set when all slots are committed or when the open slot already holds a full block.
- R4: A slot committed with cmd_xme carries tx_last on its final byte. Once that byte is accepted, tx_valid stays 0 until fr_done.
- R5: st_pool is set one cycle after a slot's final byte is accepted (tx_valid and tx_ready both high). It is also set one cycle after cmd_xres.
- R6: Suppose a frame is in progress with no end committed, no committed byte remains, and tx_ready is high. Then st_under is set, the store is emptied, and tx_abort pulses for one cycle, all in the next cycle.
- R7: A collision while the frame's first slot is still held gives no status. The frame restarts from its first byte, with tx_sof.
- R8: A collision after the frame's first slot has been released sets st_repeat, empties the store and pulses tx_abort.
- R9: While st_under or st_repeat is set, writes and commit commands have no effect.
- R10: cmd_xres empties the store and pulses tx_abort. It leaves the status bits that are already set unchanged.
- R11: stat_rd clears all status bits in the next cycle, unless a bit is set again in that same cycle, in which case that bit stays 1.
- R12: blk_sel=0 selects four 16-byte slots and blk_sel=1 selects two 32-byte slots. A 32-byte block fits in a single slot when blk_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_sel | input | 1 | Slot size: 0 = 16 bytes, 1 = 32 bytes |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| cmd_xtf | input | 1 | Commit the open slot, frame continues |
| cmd_xme | input | 1 | Commit the open slot as the frame end |
| cmd_xres | input | 1 | Transmitter reset |
| stat_rd | input | 1 | Status read strobe (clears status) |
| st_pool | output | 1 | Space-ready status |
| st_under | output | 1 | Underrun status |
| st_repeat | output | 1 | Repeat-request status |
| st_ovf | output | 1 | Overflow status |
| tx_valid | output | 1 | Byte offered to the framer |
| tx_data | output | 8 | Offered byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Framer accepts the byte |
| tx_abort | output | 1 | One-cycle abort request to the framer |
| coll | input | 1 | Collision reported by the line side |
| fr_done | input | 1 | Framer has sent the closing flag |

## Verification
Assertions check the following on every cycle:
- The start marker only ever appears at offset zero of a slot.
- Underrun and repeat each leave the store empty, with the status bit set and an abort issued.
- A rewind returns the frame to its start.
- No frame data is offered after an accepted last byte.
- Writes stay frozen while an error status is pending.
- Status bits hold until they are read.

Only the bench scenarios can show the rest:
- Byte order across slots of both sizes.
- The exact cycle at which space is released.
- The choice between rewind and repeat depending on when the collision arrives.
- A reset in mid-frame.
- Set-wins-over-clear when a read and an event coincide.

These are all compared against a behavioural queue model on every clock.

// File: rtl/hdlc_txbuf_pkg.sv
package hdlc_txbuf_pkg;
    localparam int DW      = 8;
    localparam int DEPTH   = 64;
    localparam int MINBLK  = 16;
    localparam int MAXBLK  = 32;
    localparam int MAXSLOT = DEPTH / MINBLK;
    localparam int AW      = $clog2(DEPTH);
    localparam int SW      = $clog2(MAXSLOT);
    localparam int LW      = $clog2(MAXBLK) + 1;
    localparam int NSTAT   = 4;

    typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WAIT} tx_state_e;

    typedef struct packed {
        logic ovf;
        logic rep;
        logic und;
        logic pool;
    } stat_t;

    function automatic logic [LW-1:0] blk_len(input logic sel);
        return sel ? LW'(MAXBLK) : LW'(MINBLK);
    endfunction

    function automatic logic [SW:0] slot_count(input logic sel);
        return sel ? (SW+1)'(DEPTH / MAXBLK) : (SW+1)'(MAXSLOT);
    endfunction

    function automatic logic [SW-1:0] slot_next(input logic [SW-1:0] slot, input logic sel);
        return ((SW+1)'(slot) + (SW+1)'(1) == slot_count(sel)) ? '0 : slot + SW'(1);
    endfunction

    function automatic logic [AW-1:0] byte_addr(input logic [SW-1:0] slot,
                                                input logic [LW-1:0] off,
                                                input logic sel);
        return AW'(32'(slot) * 32'(blk_len(sel)) + 32'(off));
    endfunction
endpackage

// File: rtl/hdlc_txbuf_store.sv
module hdlc_txbuf_store
    import hdlc_txbuf_pkg::*;
(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/hdlc_txbuf_slots.sv
module hdlc_txbuf_slots
    import hdlc_txbuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] wslot,
    input  logic [LW-1:0] wlen,
    input  logic          weom,
    input  logic [SW-1:0] rslot,
    output logic [LW-1:0] rlen,
    output logic          reom
);
    logic [MAXSLOT-1:0][LW-1:0] len_all;
    logic [MAXSLOT-1:0]         eom_all;

    for (genvar g = 0; g < MAXSLOT; g++) begin : g_slot
        logic [LW-1:0] len_q;
        logic          eom_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                len_q <= '0;
                eom_q <= 1'b0;
            end else if (we && wslot == SW'(g)) begin
                len_q <= wlen;
                eom_q <= weom;
            end
        end
        assign len_all[g] = len_q;
        assign eom_all[g] = eom_q;
    end

    assign rlen = len_all[rslot];
    assign reom = eom_all[rslot];
endmodule

// File: rtl/hdlc_txbuf_stat.sv
module hdlc_txbuf_stat
    import hdlc_txbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] set,
    input  logic             clr,
    output logic [NSTAT-1:0] st
);
    logic [NSTAT-1:0] st_q;

    for (genvar i = 0; i < NSTAT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) st_q[i] <= 1'b0;
            else     st_q[i] <= (st_q[i] && !clr) || set[i];
        end

        p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
            (st_q[i] && !clr) |=> st_q[i]);
    end

    assign st = st_q;
endmodule

// File: rtl/hdlc_txbuf.sv
module hdlc_txbuf
    import hdlc_txbuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          blk_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          cmd_xtf,
    input  logic          cmd_xme,
    input  logic          cmd_xres,
    input  logic          stat_rd,
    output logic          st_pool,
    output logic          st_under,
    output logic          st_repeat,
    output logic          st_ovf,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_sof,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          tx_abort,
    input  logic          coll,
    input  logic          fr_done
);
    logic [SW-1:0] wslot_q, rslot_q;
    logic [LW-1:0] woff_q, roff_q;
    logic [SW:0]   used_q;
    tx_state_e     state_q;
    logic          first_q;
    logic          abort_q;

    stat_t         st, st_set;
    logic [NSTAT-1:0] st_vec;
    logic [LW-1:0] cur_len, cm_len;
    logic          cur_eom;
    logic [DW-1:0] rd_byte;
    logic [SW:0]   nslot;
    logic          pend, fits, wr_ok, ovf_set, cm, acc, blk_end;
    logic          coll_evt, rewind, rep_evt, und_evt, flush, rel;

    always_comb begin
        nslot    = slot_count(blk_sel);
        pend     = st.und | st.rep;
        tx_valid = (state_q != TX_WAIT) && (used_q != '0) && !pend;
        tx_sof   = tx_valid && (state_q == TX_IDLE);
        tx_last  = tx_valid && cur_eom && (roff_q == cur_len - LW'(1));
        tx_data  = rd_byte;
        acc      = tx_valid && tx_ready;
        blk_end  = acc && (roff_q == cur_len - LW'(1));
        coll_evt = coll && (state_q != TX_IDLE) && !cmd_xres;
        rewind   = coll_evt && first_q;
        rep_evt  = coll_evt && !first_q;
        und_evt  = !coll_evt && (state_q == TX_SEND) && (used_q == '0) && tx_ready && !cmd_xres;
        flush    = cmd_xres || und_evt || rep_evt;
        fits     = (used_q < nslot) && (woff_q != blk_len(blk_sel));
        wr_ok    = wr_en && !pend && !flush && fits;
        ovf_set  = wr_en && !pend && !cmd_xres && !fits;
        cm_len   = woff_q + LW'(wr_ok);
        cm       = (cmd_xtf || cmd_xme) && !pend && !flush && (cm_len != '0);
        rel      = blk_end && !flush && !rewind;
        st_set   = '{ovf: ovf_set, rep: rep_evt, und: und_evt, pool: rel || cmd_xres};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wslot_q <= '0;
            rslot_q <= '0;
            woff_q  <= '0;
            roff_q  <= '0;
            used_q  <= '0;
            state_q <= TX_IDLE;
            first_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            abort_q <= flush;
            if (flush) begin
                wslot_q <= '0;
                rslot_q <= '0;
                woff_q  <= '0;
                roff_q  <= '0;
                used_q  <= '0;
                state_q <= TX_IDLE;
                first_q <= 1'b0;
            end else begin
                if (cm) begin
                    woff_q  <= '0;
                    wslot_q <= slot_next(wslot_q, blk_sel);
                end else if (wr_ok) begin
                    woff_q  <= woff_q + LW'(1);
                end
                used_q <= used_q + (SW+1)'(cm) - (SW+1)'(rel);
                if (rewind) begin
                    roff_q  <= '0;
                    state_q <= TX_IDLE;
                    first_q <= 1'b0;
                end else begin
                    if (state_q == TX_WAIT && fr_done) state_q <= TX_IDLE;
                    if (acc) begin
                        if (blk_end) begin
                            roff_q  <= '0;
                            rslot_q <= slot_next(rslot_q, blk_sel);
                            first_q <= 1'b0;
                            state_q <= cur_eom ? TX_WAIT : TX_SEND;
                        end else begin
                            roff_q <= roff_q + LW'(1);
                            if (state_q == TX_IDLE) begin
                                state_q <= TX_SEND;
                                first_q <= 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    hdlc_txbuf_store u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (byte_addr(wslot_q, woff_q, blk_sel)),
        .wdata (wr_data),
        .raddr (byte_addr(rslot_q, roff_q, blk_sel)),
        .rdata (rd_byte)
    );

    hdlc_txbuf_slots u_slots (
        .clk   (clk),
        .rst   (rst),
        .we    (cm),
        .wslot (wslot_q),
        .wlen  (cm_len),
        .weom  (cmd_xme),
        .rslot (rslot_q),
        .rlen  (cur_len),
        .reom  (cur_eom)
    );

    hdlc_txbuf_stat u_stat (
        .clk (clk),
        .rst (rst),
        .set (st_set),
        .clr (stat_rd),
        .st  (st_vec)
    );

    assign st        = stat_t'(st_vec);
    assign st_pool   = st.pool;
    assign st_under  = st.und;
    assign st_repeat = st.rep;
    assign st_ovf    = st.ovf;
    assign tx_abort  = abort_q;

    p_sof_at_start_r2: assert property (@(posedge clk) disable iff (rst)
        tx_sof |-> (roff_q == '0));
    p_last_then_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && tx_last && !flush && !rewind) |=> !tx_valid);
    p_under_empties_r6: assert property (@(posedge clk) disable iff (rst)
        und_evt |=> (used_q == '0) && tx_abort && st_under);
    p_rewind_restart_r7: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (state_q == TX_IDLE) && (roff_q == '0) && !st_repeat);
    p_repeat_flush_r8: assert property (@(posedge clk) disable iff (rst)
        rep_evt |=> st_repeat && (used_q == '0) && tx_abort);
    p_pend_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        pend |=> ($stable(woff_q) || woff_q == '0));
    p_xres_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_xres && st_ovf && !stat_rd) |=> (st_ovf && tx_abort && !tx_valid));
    p_slot_bound_r12: assert property (@(posedge clk) disable iff (rst)
        used_q <= nslot);
endmodule

// File: tb/hdlc_txbuf_tb_top.sv
`timescale 1ns/100ps
module hdlc_txbuf_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic blk_sel = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic cmd_xtf = 1'b0, cmd_xme = 1'b0, cmd_xres = 1'b0, stat_rd = 1'b0;
    logic st_pool, st_under, st_repeat, st_ovf;
    logic tx_valid, tx_sof, tx_last, tx_abort;
    logic [7:0] tx_data;
    logic tx_ready = 1'b0;
    logic coll = 1'b0, fr_done = 1'b0;

    always #2 clk = ~clk;

    hdlc_txbuf dut_i (.*);

    int nchk = 0, nfail = 0;
    bit started = 0, slow = 0, finished = 0;

    // behavioural reference model
    logic [7:0] bdata[$];
    logic [7:0] cur[$];
    int  blen[$];
    bit  beom[$];
    int  roff = 0, m_state = 0;
    bit  fh = 0, m_pool = 0, m_und = 0, m_rep = 0, m_ovf = 0, m_abort = 0;

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int  used, nslot, blk, clen, len0;
        bit  pend, ev, el, es, ce, rew, rep, und, flush, fits, wok, oset, cm, acc, bend, rel, e0;
        logic [7:0] ed;
        bit bad;
        used  = blen.size();
        pend  = m_und || m_rep;
        ev    = (m_state != 2) && used > 0 && !pend;
        ed    = ev ? bdata[roff] : 8'h00;
        es    = ev && m_state == 0;
        el    = ev && beom[0] && roff == blen[0] - 1;
        bad   = 0;
        nchk++;
        if (tx_valid !== ev) begin bad = 1; $display("FAIL R2 tx_valid actual=%0d expected=%0d", tx_valid, ev); end
        if (ev && tx_data !== ed) begin bad = 1; $display("FAIL R2 tx_data actual=%0h expected=%0h", tx_data, ed); end
        if (ev && tx_sof !== es) begin bad = 1; $display("FAIL R2 tx_sof actual=%0d expected=%0d", tx_sof, es); end
        if (ev && tx_last !== el) begin bad = 1; $display("FAIL R4 tx_last actual=%0d expected=%0d", tx_last, el); end
        if (st_pool !== m_pool) begin bad = 1; $display("FAIL R5 st_pool actual=%0d expected=%0d", st_pool, m_pool); end
        if (st_under !== m_und) begin bad = 1; $display("FAIL R6 st_under actual=%0d expected=%0d", st_under, m_und); end
        if (st_repeat !== m_rep) begin bad = 1; $display("FAIL R8 st_repeat actual=%0d expected=%0d", st_repeat, m_rep); end
        if (st_ovf !== m_ovf) begin bad = 1; $display("FAIL R3 st_ovf actual=%0d expected=%0d", st_ovf, m_ovf); end
        if (tx_abort !== m_abort) begin bad = 1; $display("FAIL R10 tx_abort actual=%0d expected=%0d", tx_abort, m_abort); end
        if (bad) nfail++;
        if (rst) begin
            bdata.delete(); cur.delete(); blen.delete(); beom.delete();
            roff = 0; m_state = 0; fh = 0;
            m_pool = 0; m_und = 0; m_rep = 0; m_ovf = 0; m_abort = 0;
            return;
        end
        nslot = blk_sel ? 2 : 4;
        blk   = blk_sel ? 32 : 16;
        ce    = coll && m_state != 0 && !cmd_xres;
        rew   = ce && fh;
        rep   = ce && !fh;
        und   = !ce && m_state == 1 && used == 0 && tx_ready && !cmd_xres;
        flush = cmd_xres || und || rep;
        fits  = used < nslot && cur.size() < blk;
        wok   = wr_en && !pend && !flush && fits;
        oset  = wr_en && !pend && !cmd_xres && !fits;
        clen  = cur.size() + (wok ? 1 : 0);
        cm    = (cmd_xtf || cmd_xme) && !pend && !flush && clen > 0;
        acc   = ev && tx_ready;
        bend  = acc && roff == blen[0] - 1;
        rel   = bend && !flush && !rew;
        m_pool = (m_pool && !stat_rd) || rel || cmd_xres;
        m_und  = (m_und && !stat_rd) || und;
        m_rep  = (m_rep && !stat_rd) || rep;
        m_ovf  = (m_ovf && !stat_rd) || oset;
        m_abort = flush;
        if (flush) begin
            bdata.delete(); cur.delete(); blen.delete(); beom.delete();
            roff = 0; m_state = 0; fh = 0;
            return;
        end
        if (rew) begin
            roff = 0; m_state = 0; fh = 0;
        end else begin
            if (m_state == 2 && fr_done) m_state = 0;
            if (acc) begin
                if (bend) begin
                    e0 = beom[0]; len0 = blen[0];
                    for (int k = 0; k < len0; k++) void'(bdata.pop_front());
                    void'(blen.pop_front()); void'(beom.pop_front());
                    roff = 0; fh = 0;
                    m_state = e0 ? 2 : 1;
                end else begin
                    roff++;
                    if (m_state == 0) begin m_state = 1; fh = 1; end
                end
            end
        end
        if (wok) cur.push_back(wr_data);
        if (cm) begin
            foreach (cur[k]) bdata.push_back(cur[k]);
            blen.push_back(clen);
            beom.push_back(cmd_xme);
            cur.delete();
        end
    endtask

    always begin
        @(negedge clk);
        #1;
        if (started && !finished) model_step();
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #0.5;
            wr_en = 0; cmd_xtf = 0; cmd_xme = 0; cmd_xres = 0;
            stat_rd = 0; coll = 0; fr_done = 0;
            if (slow) tx_ready = ~tx_ready;
        end
    endtask

    task automatic wbyte(logic [7:0] d);
        wr_en = 1; wr_data = d; tick(1);
    endtask

    task automatic wblock(int n, int base, bit last);
        for (int i = 0; i < n; i++) wbyte(8'(base + i));
        if (last) cmd_xme = 1; else cmd_xtf = 1;
        tick(1);
    endtask

    task automatic clean(bit sel);
        blk_sel = sel; cmd_xres = 1; tick(1);
        stat_rd = 1; tick(1);
        tick(2);
    endtask

    task automatic wait_end();
        int n = 0;
        while (m_state != 2 && n < 3000) begin tick(1); n++; end
        tick(3);
        fr_done = 1; tick(1);
    endtask

    task automatic wait_pool();
        int n = 0;
        while (!st_pool && n < 3000) begin tick(1); n++; end
        stat_rd = 1; tick(1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        @(posedge clk); started = 1;
        tick(3);
        rst = 0;
        // R1 reset state
        chk("R1 st_pool", st_pool, 0);
        chk("R1 st_ovf", st_ovf, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 tx_abort", tx_abort, 0);
        tick(2);

        // two-block frame, 16-byte slots, fast framer (R2 R4 R5)
        tx_ready = 1;
        wblock(16, 8'h10, 0);
        wblock(10, 8'h40, 1);
        wait_end();
        chk("R5 st_pool after release", st_pool, 1);
        chk("R4 idle after done", tx_valid, 0);
        clean(1);

        // three blocks, 32-byte slots, half-rate framer (R12)
        slow = 1;
        wblock(32, 8'h60, 0);
        chk("R12 32-byte block fits one slot", st_ovf, 0);
        wblock(32, 8'hA0, 0);
        wait_pool();
        wblock(5, 8'h05, 1);
        wait_end();
        slow = 0; tx_ready = 0;
        clean(0);

        // overflow, reset in mid-frame, read-to-clear (R3 R10 R11)
        for (int i = 0; i < 17; i++) wbyte(8'(i));
        chk("R3 17th byte overflows", st_ovf, 1);
        cmd_xtf = 1; tick(1);
        wblock(4, 8'h30, 1);
        tx_ready = 1; tick(6);
        cmd_xres = 1; tick(1);
        chk("R10 abort pulse", tx_abort, 1);
        chk("R10 store empty", tx_valid, 0);
        chk("R10 status kept", st_ovf, 1);
        chk("R5 pool after reset", st_pool, 1);
        stat_rd = 1; cmd_xres = 1; tick(1);
        chk("R11 set wins over clear", st_pool, 1);
        chk("R11 ovf cleared", st_ovf, 0);
        clean(0);

        // underrun from a slow host (R6 R9)
        wblock(16, 8'h80, 0);
        tick(40);
        chk("R6 underrun raised", st_under, 1);
        wblock(3, 8'h01, 0);
        chk("R9 commit ignored while pending", tx_valid, 0);
        stat_rd = 1; tick(1);
        tick(1);
        chk("R9 no data after pending cleared", tx_valid, 0);
        chk("R11 underrun cleared", st_under, 0);
        clean(0);

        // collision after first block (R8)
        tx_ready = 0;
        wblock(16, 8'h20, 0);
        wblock(8, 8'h50, 1);
        tx_ready = 1; tick(20);
        coll = 1; tick(1);
        chk("R8 repeat raised", st_repeat, 1);
        chk("R8 store emptied", tx_valid, 0);
        clean(0);

        // collision inside first block (R7)
        tx_ready = 0;
        wblock(16, 8'hC0, 0);
        wblock(8, 8'hE0, 1);
        tx_ready = 1; tick(5);
        coll = 1; tick(1);
        chk("R7 restart with sof", tx_sof, 1);
        chk("R7 restart first byte", tx_data, 8'hC0);
        chk("R7 no repeat status", st_repeat, 0);
        wait_end();
        chk("R7 frame completed", st_under, 0);
        tick(4);
        summary();
    end
endmodule